// File: doc/BRIEF.md
# Three-Port Register File with Wrapping Multi-Word Operands

This block holds the working registers of a 16-bit processor datapath: 24 words of 16 bits. Two read ports and one write port all operate in the same clock cycle. The sixteen low entries are the general registers that user-level code may name. The eight high entries are scratch words that only the microcode path may use. Reads are combinational. Writes commit on the rising clock edge.

Each port carries a width code that selects one, two or three words. A multi-word operand is built from consecutive general registers. The register number wraps modulo 16, so the register after number 15 is number 0. The first named register is the most significant word of the operand. A read that hits a word being written in the same cycle returns the new value; this applies separately to every word of the operand.

A mode input selects user mode or microcode mode. An illegal access raises an error flag for its port, returns zero on a read, and changes no storage on a write. The asynchronous active-low reset is released through a two-stage synchronizer, and reset clears every entry.

Top module: `rf3p_regfile`

## Requirements
- R1: After reset every one of the 24 entries reads as zero.
- R2: A single-word write (width code 0) to entry n is visible on both read ports from the next cycle, and the two read ports return independent entries in the same cycle; a single-word read returns the entry in bits 15:0 with bits 47:16 zero.
- R3: A two-word read (width code 1) of base n returns R[n] in bits 31:16 and R[(n+1) mod 16] in bits 15:0, with bits 47:32 zero.
- R4: A three-word read (width code 2) of base n returns R[n] in bits 47:32, R[(n+1) mod 16] in bits 31:16 and R[(n+2) mod 16] in bits 15:0.
- R5: Multi-word reads wrap: base 15 with two words pairs R15 with R0, and bases 14 and 15 with three words continue into R0 and R1.
- R6: A multi-word write stores all of its words in one cycle: the word in the same bit position as in R3/R4 goes to the matching wrapped register index.
- R7: A read word whose register is being written in the same cycle returns the new value (write-first), checked per word of a multi-word read; the other words return the stored values.
- R8: In user mode (mode input 0) any access to entries 16 to 23 sets that port's error flag: a read returns zero and a write leaves the storage unchanged.
- R9: In microcode mode (mode input 1) single-word access to entries 16 to 23 works normally; a multi-word access with a base of 16 or more is an error in either mode.
- R10: Width code 3 is reserved: the port's error flag is set, a read returns zero and a write leaves the storage unchanged.
- R11: User-mode single- and multi-word accesses to entries 0 to 15 raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mcode_i | input | 1 | Access mode: 1 microcode, 0 user |
| rd0_sel_i | input | 5 | Read port 0 base register |
| rd0_wd_i | input | 2 | Read port 0 width code (0,1,2 words+1; 3 reserved) |
| rd0_data_o | output | 48 | Read port 0 operand |
| rd0_err_o | output | 1 | Read port 0 access error |
| rd1_sel_i | input | 5 | Read port 1 base register |
| rd1_wd_i | input | 2 | Read port 1 width code |
| rd1_data_o | output | 48 | Read port 1 operand |
| rd1_err_o | output | 1 | Read port 1 access error |
| wr_en_i | input | 1 | Write request |
| wr_sel_i | input | 5 | Write base register |
| wr_wd_i | input | 2 | Write width code |
| wr_data_i | input | 48 | Write operand, same layout as the reads |
| wr_err_o | output | 1 | Write access error, valid while wr_en_i is high |

## Verification
The bench builds the block with its defaults: 16-bit words, 16 general registers and 8 scratch registers. At this size the wrap boundary sits at a real index, so bases 14 and 15 exercise both the two-word and the three-word wrap into R0 and R1. Every scratch index lies just past that boundary, which puts the privilege gate and the rule against multi-word scratch access next to the wrap cases. A write that spans the wrap is combined with a dual read of overlapping words, so the write-first path is seen both on words that take the new value and on words that keep the stored one.

// File: rtl/rf3p_pkg.sv
package rf3p_pkg;

  // Number of words a single operand may span (fixed by the width code)
  localparam int unsigned MAX_WORDS = 3;

  typedef enum logic [1:0] {
    WD_ONE   = 2'd0,
    WD_TWO   = 2'd1,
    WD_THREE = 2'd2,
    WD_RSVD  = 2'd3
  } width_e;

  function automatic logic [MAX_WORDS-1:0] word_mask(input width_e wd);
    case (wd)
      WD_ONE:   word_mask = 3'b001;
      WD_TWO:   word_mask = 3'b011;
      WD_THREE: word_mask = 3'b111;
      default:  word_mask = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/rf3p_rst_sync.sv
module rf3p_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/rf3p_sel_decode.sv
module rf3p_sel_decode
  import rf3p_pkg::*;
#(
  parameter int unsigned GPR_N = 16,
  parameter int unsigned SEL_W = 5
) (
  input  logic [SEL_W-1:0]                 sel_i,
  input  width_e                           wd_i,
  input  logic                             mcode_i,
  output logic [MAX_WORDS-1:0][SEL_W-1:0]  idx_o,
  output logic [MAX_WORDS-1:0]             mask_o,
  output logic                             viol_o
);

  localparam logic [SEL_W-1:0] GPR_LIM = SEL_W'(GPR_N);

  logic is_scr;

  always_comb begin
    is_scr = (sel_i >= GPR_LIM);
    for (int k = 0; k < MAX_WORDS; k++) begin
      if (is_scr) begin
        idx_o[k] = sel_i;
      end else begin
        idx_o[k] = SEL_W'((int'(sel_i) + k) % GPR_N);
      end
    end
    mask_o = word_mask(wd_i);
    viol_o = (wd_i == WD_RSVD) || (is_scr && (!mcode_i || (wd_i != WD_ONE)));
  end

endmodule

// File: rtl/rf3p_rd_port.sv
module rf3p_rd_port
  import rf3p_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 24,
  parameter int unsigned SEL_W  = 5,
  localparam int unsigned OP_W  = MAX_WORDS * DATA_W
) (
  input  logic [DEPTH-1:0][DATA_W-1:0]      mem_i,
  input  logic [MAX_WORDS-1:0][SEL_W-1:0]   idx_i,
  input  width_e                            wd_i,
  input  logic                              viol_i,
  input  logic [MAX_WORDS-1:0]              byp_en_i,
  input  logic [MAX_WORDS-1:0][SEL_W-1:0]   byp_idx_i,
  input  logic [MAX_WORDS-1:0][DATA_W-1:0]  byp_word_i,
  output logic [OP_W-1:0]                   data_o
);

  logic [MAX_WORDS-1:0][DATA_W-1:0] val;

  // per-word storage fetch with write-first override
  always_comb begin
    for (int k = 0; k < MAX_WORDS; k++) begin
      val[k] = mem_i[idx_i[k]];
      for (int j = 0; j < MAX_WORDS; j++) begin
        if (byp_en_i[j] && (byp_idx_i[j] == idx_i[k])) begin
          val[k] = byp_word_i[j];
        end
      end
    end
  end

  // operand assembly: first word is most significant
  always_comb begin
    data_o = '0;
    if (!viol_i) begin
      case (wd_i)
        WD_ONE:   data_o = OP_W'(val[0]);
        WD_TWO:   data_o = OP_W'({val[0], val[1]});
        WD_THREE: data_o = {val[0], val[1], val[2]};
        default:  data_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/rf3p_store.sv
module rf3p_store
  import rf3p_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 24,
  parameter int unsigned SEL_W  = 5
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_go_i,
  input  logic [MAX_WORDS-1:0]              mask_i,
  input  logic [MAX_WORDS-1:0][SEL_W-1:0]   idx_i,
  input  logic [MAX_WORDS-1:0][DATA_W-1:0]  word_i,
  output logic [DEPTH-1:0][DATA_W-1:0]      mem_o
);

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0][DATA_W-1:0] mem_d;
  logic [DEPTH-1:0]             ent_we;

  // next-state: select which entries take which write word
  always_comb begin
    for (int e = 0; e < DEPTH; e++) begin
      ent_we[e] = 1'b0;
      mem_d[e]  = mem_q[e];
      for (int k = 0; k < MAX_WORDS; k++) begin
        if (wr_go_i && mask_i[k] && (idx_i[k] == SEL_W'(e))) begin
          ent_we[e] = 1'b1;
          mem_d[e]  = word_i[k];
        end
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (ent_we[g]) begin
        mem_q[g] <= mem_d[g];
      end
    end
  end

  assign mem_o = mem_q;

endmodule

// File: rtl/rf3p_regfile.sv
module rf3p_regfile
  import rf3p_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GPR_N  = 16,
  parameter int unsigned SCR_N  = 8,
  localparam int unsigned DEPTH = GPR_N + SCR_N,
  localparam int unsigned SEL_W = $clog2(DEPTH),
  localparam int unsigned OP_W  = MAX_WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mcode_i,
  input  logic [SEL_W-1:0]  rd0_sel_i,
  input  logic [1:0]        rd0_wd_i,
  output logic [OP_W-1:0]   rd0_data_o,
  output logic              rd0_err_o,
  input  logic [SEL_W-1:0]  rd1_sel_i,
  input  logic [1:0]        rd1_wd_i,
  output logic [OP_W-1:0]   rd1_data_o,
  output logic              rd1_err_o,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [1:0]        wr_wd_i,
  input  logic [OP_W-1:0]   wr_data_i,
  output logic              wr_err_o
);

  localparam int unsigned NPORT = 3; // 0,1 read; 2 write

  logic                              rst_sync_n;
  logic [NPORT-1:0][SEL_W-1:0]       p_sel;
  width_e                            p_wd   [NPORT];
  logic [NPORT-1:0]                  p_viol;
  logic [MAX_WORDS-1:0][SEL_W-1:0]   p_idx  [NPORT];
  logic [MAX_WORDS-1:0]              p_mask [NPORT];

  logic [DEPTH-1:0][DATA_W-1:0]      mem_q;
  logic [MAX_WORDS-1:0][DATA_W-1:0]  wr_word;
  logic [MAX_WORDS-1:0]              wr_live;
  logic                              wr_go;
  logic [NPORT-2:0][OP_W-1:0]        rd_data;

  rf3p_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  assign p_sel = {wr_sel_i, rd1_sel_i, rd0_sel_i};

  always_comb begin
    p_wd[0] = width_e'(rd0_wd_i);
    p_wd[1] = width_e'(rd1_wd_i);
    p_wd[2] = width_e'(wr_wd_i);
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    rf3p_sel_decode #(
      .GPR_N (GPR_N),
      .SEL_W (SEL_W)
    ) u_dec (
      .sel_i   (p_sel[p]),
      .wd_i    (p_wd[p]),
      .mcode_i (mcode_i),
      .idx_o   (p_idx[p]),
      .mask_o  (p_mask[p]),
      .viol_o  (p_viol[p])
    );
  end

  // split the write operand into words, first word most significant
  always_comb begin
    wr_word = '0;
    case (p_wd[2])
      WD_ONE: begin
        wr_word[0] = wr_data_i[DATA_W-1:0];
      end
      WD_TWO: begin
        wr_word[0] = wr_data_i[2*DATA_W-1:DATA_W];
        wr_word[1] = wr_data_i[DATA_W-1:0];
      end
      WD_THREE: begin
        wr_word[0] = wr_data_i[3*DATA_W-1:2*DATA_W];
        wr_word[1] = wr_data_i[2*DATA_W-1:DATA_W];
        wr_word[2] = wr_data_i[DATA_W-1:0];
      end
      default: wr_word = '0;
    endcase
  end

  always_comb begin
    wr_go   = wr_en_i && !p_viol[2];
    wr_live = wr_go ? p_mask[2] : '0;
  end

  rf3p_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .SEL_W  (SEL_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .wr_go_i (wr_go),
    .mask_i  (p_mask[2]),
    .idx_i   (p_idx[2]),
    .word_i  (wr_word),
    .mem_o   (mem_q)
  );

  for (genvar r = 0; r < NPORT - 1; r++) begin : g_rd
    rf3p_rd_port #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .SEL_W  (SEL_W)
    ) u_rd (
      .mem_i      (mem_q),
      .idx_i      (p_idx[r]),
      .wd_i       (p_wd[r]),
      .viol_i     (p_viol[r]),
      .byp_en_i   (wr_live),
      .byp_idx_i  (p_idx[2]),
      .byp_word_i (wr_word),
      .data_o     (rd_data[r])
    );
  end

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];
  assign rd0_err_o  = p_viol[0];
  assign rd1_err_o  = p_viol[1];
  assign wr_err_o   = wr_en_i && p_viol[2];

endmodule

// File: rtl/rf3p_chk.sv
module rf3p_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 24,
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned GPR_N  = 16,
  parameter int unsigned OP_W   = 48
) (
  input logic                         clk_i,
  input logic                         rst_sync_n,
  input logic                         mcode_i,
  input logic [SEL_W-1:0]             rd0_sel_i,
  input logic [1:0]                   rd0_wd_i,
  input logic [OP_W-1:0]              rd0_data_o,
  input logic                         rd0_err_o,
  input logic                         wr_en_i,
  input logic [SEL_W-1:0]             wr_sel_i,
  input logic [1:0]                   wr_wd_i,
  input logic [OP_W-1:0]              wr_data_i,
  input logic                         wr_err_o,
  input logic [DEPTH-1:0][DATA_W-1:0] mem_q
);

  localparam logic [SEL_W-1:0] LIM = SEL_W'(GPR_N);

  // R8: a flagged read returns zero
  p_err_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    rd0_err_o |-> (rd0_data_o == '0));

  // R8: user access to scratch entries is flagged
  p_user_scratch_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (!mcode_i && (rd0_sel_i >= LIM)) |-> rd0_err_o);

  // R8, R10: a flagged write leaves storage unchanged
  p_wr_suppress_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && wr_err_o) |=> $stable(mem_q));

  // R10: reserved width code is always flagged
  p_rsvd_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rd0_wd_i == 2'd3) |-> rd0_err_o);

  // R2: single-word read leaves upper bits zero
  p_single_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rd0_wd_i == 2'd0) |-> (rd0_data_o[OP_W-1:DATA_W] == '0));

  // R3: two-word read leaves top word zero
  p_double_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (rd0_wd_i == 2'd1) |-> (rd0_data_o[OP_W-1:2*DATA_W] == '0));

  // R7: same-entry single-word read sees the word being written
  p_bypass_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && !wr_err_o && (wr_wd_i == 2'd0) && (rd0_wd_i == 2'd0) &&
     !rd0_err_o && (rd0_sel_i == wr_sel_i))
    |-> (rd0_data_o[DATA_W-1:0] == wr_data_i[DATA_W-1:0]));

  // R2: an accepted single-word write lands in its entry
  p_wr_store_r2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wr_en_i && !wr_err_o && (wr_wd_i == 2'd0))
    |=> (mem_q[$past(wr_sel_i)] == $past(wr_data_i[DATA_W-1:0])));

endmodule

bind rf3p_regfile rf3p_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .SEL_W  (SEL_W),
  .GPR_N  (GPR_N),
  .OP_W   (OP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .mcode_i    (mcode_i),
  .rd0_sel_i  (rd0_sel_i),
  .rd0_wd_i   (rd0_wd_i),
  .rd0_data_o (rd0_data_o),
  .rd0_err_o  (rd0_err_o),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_wd_i    (wr_wd_i),
  .wr_data_i  (wr_data_i),
  .wr_err_o   (wr_err_o),
  .mem_q      (mem_q)
);

// File: tb/sim_rf3p_regfile.sv
module sim_rf3p_regfile;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mcode_i;
  logic [4:0]  rd0_sel_i, rd1_sel_i, wr_sel_i;
  logic [1:0]  rd0_wd_i, rd1_wd_i, wr_wd_i;
  logic [47:0] rd0_data_o, rd1_data_o, wr_data_i;
  logic        rd0_err_o, rd1_err_o, wr_en_i, wr_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] model [24];

  always #5 clk_i = ~clk_i;

  rf3p_regfile u0 (.*);

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_viol(input bit mc, input int sel, input int wd);
    return (wd == 3) || ((sel >= 16) && (!mc || (wd != 0)));
  endfunction

  function automatic logic [47:0] exp_rd(input bit mc, input int sel, input int wd);
    logic [47:0] r = '0;
    if (exp_viol(mc, sel, wd)) return '0;
    if (sel >= 16) return {32'h0, model[sel]};
    for (int k = 0; k <= wd; k++) r = (r << 16) | 48'(model[(sel + k) % 16]);
    return r;
  endfunction

  task automatic model_wr(input bit mc, input int sel, input int wd, input logic [47:0] d);
    if (exp_viol(mc, sel, wd)) return;
    for (int k = 0; k <= wd; k++) begin
      int tgt = (sel >= 16) ? sel : (sel + k) % 16;
      model[tgt] = d[(wd - k) * 16 +: 16];
    end
  endtask

  task automatic wr(input string tag, input bit mc, input int sel, input int wd,
                    input logic [47:0] d);
    @(negedge clk_i);
    mcode_i = mc; wr_en_i = 1'b1; wr_sel_i = 5'(sel); wr_wd_i = 2'(wd); wr_data_i = d;
    #1;
    chk({tag, " wr_err"}, 48'(wr_err_o), 48'(exp_viol(mc, sel, wd)));
    @(posedge clk_i);
    #2;
    wr_en_i = 1'b0;
    model_wr(mc, sel, wd, d);
  endtask

  task automatic rd(input string tag, input bit mc, input int s0, input int w0,
                    input int s1, input int w1);
    @(negedge clk_i);
    mcode_i = mc; rd0_sel_i = 5'(s0); rd0_wd_i = 2'(w0); rd1_sel_i = 5'(s1); rd1_wd_i = 2'(w1);
    #1;
    chk({tag, " rd0"}, rd0_data_o, exp_rd(mc, s0, w0));
    chk({tag, " rd0_err"}, 48'(rd0_err_o), 48'(exp_viol(mc, s0, w0)));
    chk({tag, " rd1"}, rd1_data_o, exp_rd(mc, s1, w1));
    chk({tag, " rd1_err"}, 48'(rd1_err_o), 48'(exp_viol(mc, s1, w1)));
  endtask

  task automatic t_reset;
    for (int i = 0; i < 24; i += 2) rd("R1 reset", 1'b1, i, 0, i + 1, 0);
  endtask

  task automatic t_single;
    for (int i = 0; i < 16; i++) wr("R2 fill", 1'b1, i, 0, 48'(16'h1000 + i * 16'h0111));
    wr("R9 scratch wr", 1'b1, 20, 0, 48'h0000_0000_BEEF);
    rd("R2 dual", 1'b1, 3, 0, 12, 0);
    rd("R9 scratch rd", 1'b1, 20, 0, 7, 0);
  endtask

  task automatic t_multi_read;
    rd("R3 two-word", 1'b1, 7, 1, 2, 1);
    rd("R4 three-word", 1'b1, 9, 2, 0, 2);
    rd("R5 wrap 15x2 14x3", 1'b1, 15, 1, 14, 2);
    rd("R5 wrap 15x3", 1'b1, 15, 2, 13, 2);
    chk("R5 explicit R15:R0", rd0_data_o, {model[15], model[0], model[1]});
  endtask

  task automatic t_multi_write;
    wr("R6 wrap write", 1'b1, 15, 2, 48'hA1A1_B2B2_C3C3);
    rd("R6 check R15 R0", 1'b1, 15, 0, 0, 0);
    rd("R6 check R1", 1'b1, 1, 0, 2, 0);
    chk("R6 R1 value", rd0_data_o, 48'h0000_0000_C3C3);
    wr("R6 two-word", 1'b1, 14, 1, 48'h0000_D4D4_E5E5);
    rd("R6 check R14 R15", 1'b1, 14, 0, 15, 0);
  endtask

  task automatic t_bypass;
    logic [47:0] d = 48'h1111_2222_3333;
    @(negedge clk_i);
    mcode_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 5'd14; wr_wd_i = 2'd2; wr_data_i = d;
    rd0_sel_i = 5'd15; rd0_wd_i = 2'd2; rd1_sel_i = 5'd0; rd1_wd_i = 2'd0;
    #1;
    chk("R7 bypass per word", rd0_data_o, {16'h2222, 16'h3333, model[1]});
    chk("R7 bypass single", rd1_data_o, 48'h0000_0000_3333);
    @(posedge clk_i);
    #2;
    wr_en_i = 1'b0;
    model_wr(1'b1, 14, 2, d);
    rd("R7 after commit", 1'b1, 14, 2, 1, 0);
  endtask

  task automatic t_priv;
    rd("R8 user scratch", 1'b0, 16, 0, 23, 0);
    wr("R8 user scratch write", 1'b0, 20, 0, 48'h0000_0000_DEAD);
    rd("R8 scratch unchanged", 1'b1, 20, 0, 16, 0);
    rd("R11 user gpr", 1'b0, 4, 2, 15, 1);
    wr("R11 user multi write", 1'b0, 15, 1, 48'h0000_7777_8888);
    rd("R11 user readback", 1'b0, 15, 0, 0, 0);
    rd("R9 multi scratch", 1'b1, 18, 1, 22, 2);
    wr("R9 multi scratch write", 1'b1, 17, 1, 48'h0000_5A5A_A5A5);
    rd("R9 scratch unchanged", 1'b1, 17, 0, 18, 0);
    rd("R10 reserved width", 1'b1, 3, 3, 5, 3);
    wr("R10 reserved write", 1'b1, 3, 3, 48'hFFFF_FFFF_FFFF);
    rd("R10 storage unchanged", 1'b1, 3, 0, 4, 0);
  endtask

  initial begin
    rst_ni = 1'b0; mcode_i = 1'b1; wr_en_i = 1'b0;
    rd0_sel_i = '0; rd1_sel_i = '0; wr_sel_i = '0;
    rd0_wd_i = '0; rd1_wd_i = '0; wr_wd_i = '0; wr_data_i = '0;
    for (int i = 0; i < 24; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_single();
    t_multi_read();
    t_multi_write();
    t_bypass();
    t_priv();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule